// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Unit

This block is the interrupt front end of a small 8-bit processor core. It watches four hardware request lines: one that cannot be masked, one that is captured on a rising edge, and two that are sensed by level. At every instruction boundary the core signals, the unit picks the most urgent request that is allowed through. For that one cycle it raises a take pulse and drives the 16-bit address of the matching service routine.

Software controls the unit in three ways. Enable and disable commands drive a single global enable flip-flop. A mask write carries the per-line masks and can also discard a captured edge request. A status byte reports the masks, the enable state, the pending requests and a serial input bit. The unit does not push the return address, fetch instructions or handle the lowest-priority external request path; the core does those.

Top module: `vec_irq_unit`

## Requirements
- R1: When several requests are eligible at one boundary, the winner is chosen in this order, most urgent first: the non-maskable line (trapPin), r75Pin, r65Pin, r55Pin.
- R2: The vector driven with a take is 0x0024 for trapPin, 0x003C for r75Pin, 0x0034 for r65Pin and 0x002C for r55Pin.
- R3: trapPin is taken regardless of the global enable and of all three masks.
- R4: trapPin is taken only if a rising edge occurred and the pin is still high at the boundary. A pulse that falls before the boundary is lost. A pin held high after its take is not taken again until a new rising edge.
- R5: A rising edge on r75Pin is captured even while that line is masked, and it shows in status bit 6. The capture is cleared when r75Pin is taken, or by a mask write with bit 4 set.
- R6: r65Pin and r55Pin are sensed by level. Each is taken only while its pin is high, its mask bit is 0 and the global enable is 1. The mask bits are maskData bit 1 for r65Pin and bit 0 for r55Pin, and maskData bit 2 for r75Pin.
- R7: The global enable is set by eiCmd. It is cleared by diCmd, by any take and by reset. When a take and eiCmd fall in the same cycle the enable ends at 0, and when eiCmd and diCmd fall in the same cycle it also ends at 0.
- R8: Requests are acted on only in a cycle with instrEnd high. takeIrq rises on the clock edge that samples instrEnd and lasts exactly one cycle.
- R9: The status byte is {serialIn, r75 capture, r65Pin, r55Pin, global enable, mask r75, mask r65, mask r55}, from bit 7 down to bit 0.
- R10: A mask write loads maskData bits 2..0 only when maskData bit 3 is 1; otherwise the masks are left unchanged.
- R11: After reset all three masks are 1, the global enable is 0, the r75 capture is clear and takeIrq is 0, so the status byte reads 0x07 with all pins low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrEnd | input | 1 | Instruction boundary strobe from the core |
| trapPin | input | 1 | Non-maskable request, edge and level qualified |
| r75Pin | input | 1 | Maskable request, rising-edge captured |
| r65Pin | input | 1 | Maskable request, level sensed |
| r55Pin | input | 1 | Maskable request, level sensed |
| eiCmd | input | 1 | Enable-interrupts command |
| diCmd | input | 1 | Disable-interrupts command |
| maskWr | input | 1 | Mask write strobe |
| maskData | input | 5 | Mask write data: masks, load qualifier, capture clear |
| serialIn | input | 1 | Serial input bit reported in the status byte |
| statusByte | output | 8 | Packed status byte |
| takeIrq | output | 1 | One-cycle take pulse |
| vecAddr | output | 16 | Service routine address, held after the take |

## Verification
Two events can land in the same cycle: the acceptance of a request at a boundary and an enable command (or a mask write). The bench provokes this by raising eiCmd together with instrEnd while r55Pin is high and unmasked. It then checks both that the take occurs and that the enable reads 0 afterwards. It also provokes a trapPin rising edge in the boundary cycle while an r75 capture is waiting. That case is judged by the vector of the winner and by the capture still showing in the status byte until a later boundary takes it.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;

  localparam int NUM_SRC = 4;

  // Source index order is also the priority order (index 0 wins)
  typedef enum logic [1:0] {
    SRC_TRAP = 2'd0,
    SRC_R75  = 2'd1,
    SRC_R65  = 2'd2,
    SRC_R55  = 2'd3
  } irqSrcT;

  typedef struct packed {
    logic   take;
    irqSrcT src;
  } ctrlStrobeT;

  // Vector = level * 8 + 4, where the level is 4, 7, 6 or 5
  function automatic logic [5:0] srcVectorLow(irqSrcT s);
    logic [2:0] lvl;
    case (s)
      SRC_TRAP: lvl = 3'd4;
      SRC_R75:  lvl = 3'd7;
      SRC_R65:  lvl = 3'd6;
      default:  lvl = 3'd5;
    endcase
    return {lvl, 3'b100};
  endfunction

endpackage

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrEnd,
  input  logic               eiCmd,
  input  logic               diCmd,
  input  logic [NUM_SRC-1:0] reqRaw,
  input  logic [2:0]         maskBits,
  output logic               ieState,
  output ctrlStrobeT         strobe
);

  logic [NUM_SRC-1:0] eligible;
  irqSrcT             winner;

  // maskBits: [2]=r75, [1]=r65, [0]=r55
  always_comb begin
    eligible[SRC_TRAP] = reqRaw[SRC_TRAP];
    eligible[SRC_R75]  = reqRaw[SRC_R75] & ieState & ~maskBits[2];
    eligible[SRC_R65]  = reqRaw[SRC_R65] & ieState & ~maskBits[1];
    eligible[SRC_R55]  = reqRaw[SRC_R55] & ieState & ~maskBits[0];
  end

  always_comb begin
    winner = SRC_R55;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) winner = irqSrcT'(i[1:0]);
    end
  end

  always_comb begin
    strobe.take = instrEnd & (|eligible);
    strobe.src  = winner;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            ieState <= 1'b0;
    else if (strobe.take) ieState <= 1'b0;
    else if (diCmd)       ieState <= 1'b0;
    else if (eiCmd)       ieState <= 1'b1;
  end

endmodule

// File: rtl/vec_irq_dp.sv
module vec_irq_dp
  import vec_irq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trapPin,
  input  logic               r75Pin,
  input  logic               r65Pin,
  input  logic               r55Pin,
  input  logic               maskWr,
  input  logic [4:0]         maskData,
  input  logic               serialIn,
  input  logic               ieState,
  input  ctrlStrobeT         strobe,
  output logic [NUM_SRC-1:0] reqRaw,
  output logic [2:0]         maskBits,
  output logic [7:0]         statusByte,
  output logic               takeIrq,
  output logic [ADDR_W-1:0]  vecAddr
);

  localparam int EDGE_N = 2;   // 0: trap, 1: r75
  localparam int PAD_W  = ADDR_W - 6;

  logic [EDGE_N-1:0] edgeIn, edgePrev, edgeRise;
  logic              trapLatch, r75Latch;
  logic              acceptTrap, acceptR75;

  assign edgeIn = {r75Pin, trapPin};

  for (genvar g = 0; g < EDGE_N; g++) begin : gEdge
    always_ff @(posedge clk) begin
      if (!rstN) edgePrev[g] <= 1'b0;
      else       edgePrev[g] <= edgeIn[g];
    end
    assign edgeRise[g] = edgeIn[g] & ~edgePrev[g];
  end

  assign acceptTrap = strobe.take && (strobe.src == SRC_TRAP);
  assign acceptR75  = strobe.take && (strobe.src == SRC_R75);

  always_ff @(posedge clk) begin
    if (!rstN)            trapLatch <= 1'b0;
    else if (!trapPin)    trapLatch <= 1'b0;
    else if (acceptTrap)  trapLatch <= 1'b0;
    else if (edgeRise[0]) trapLatch <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                       r75Latch <= 1'b0;
    else if (acceptR75)              r75Latch <= 1'b0;
    else if (maskWr && maskData[4])  r75Latch <= 1'b0;
    else if (edgeRise[1])            r75Latch <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      maskBits <= 3'b111;
    else if (maskWr && maskData[3]) maskBits <= maskData[2:0];
  end

  always_comb begin
    reqRaw[SRC_TRAP] = trapPin & (trapLatch | edgeRise[0]);
    reqRaw[SRC_R75]  = r75Latch | edgeRise[1];
    reqRaw[SRC_R65]  = r65Pin;
    reqRaw[SRC_R55]  = r55Pin;
  end

  assign statusByte = {serialIn, r75Latch, r65Pin, r55Pin, ieState, maskBits};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeIrq <= 1'b0;
      vecAddr <= '0;
    end else begin
      takeIrq <= strobe.take;
      if (strobe.take) vecAddr <= {{PAD_W{1'b0}}, srcVectorLow(strobe.src)};
    end
  end

endmodule

// File: rtl/vec_irq_unit.sv
module vec_irq_unit
  import vec_irq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrEnd,
  input  logic              trapPin,
  input  logic              r75Pin,
  input  logic              r65Pin,
  input  logic              r55Pin,
  input  logic              eiCmd,
  input  logic              diCmd,
  input  logic              maskWr,
  input  logic [4:0]        maskData,
  input  logic              serialIn,
  output logic [7:0]        statusByte,
  output logic              takeIrq,
  output logic [ADDR_W-1:0] vecAddr
);

  ctrlStrobeT         strobe;
  logic               ieState;
  logic [NUM_SRC-1:0] reqRaw;
  logic [2:0]         maskBits;

  vec_irq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .instrEnd (instrEnd),
    .eiCmd    (eiCmd),
    .diCmd    (diCmd),
    .reqRaw   (reqRaw),
    .maskBits (maskBits),
    .ieState  (ieState),
    .strobe   (strobe)
  );

  vec_irq_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .trapPin    (trapPin),
    .r75Pin     (r75Pin),
    .r65Pin     (r65Pin),
    .r55Pin     (r55Pin),
    .maskWr     (maskWr),
    .maskData   (maskData),
    .serialIn   (serialIn),
    .ieState    (ieState),
    .strobe     (strobe),
    .reqRaw     (reqRaw),
    .maskBits   (maskBits),
    .statusByte (statusByte),
    .takeIrq    (takeIrq),
    .vecAddr    (vecAddr)
  );

endmodule

// File: rtl/vec_irq_chk.sv
module vec_irq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              instrEnd,
  input logic [7:0]        statusByte,
  input logic              takeIrq,
  input logic [ADDR_W-1:0] vecAddr
);

  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> $past(instrEnd)) else $error("take without boundary"); // R8

  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |=> !takeIrq) else $error("take longer than one cycle"); // R8

  AST_ENABLE_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> !statusByte[3]) else $error("enable survives a take"); // R7

  AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (vecAddr == 16'h0024 || vecAddr == 16'h003C ||
                 vecAddr == 16'h0034 || vecAddr == 16'h002C))
    else $error("illegal vector"); // R2

  AST_LEVEL_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && vecAddr == 16'h002C) |-> ($past(statusByte[3]) && !$past(statusByte[0])))
    else $error("r55 taken while gated"); // R6

  AST_R75_CAPTURE_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && vecAddr == 16'h003C) |-> !statusByte[6])
    else $error("r75 capture kept after take"); // R5

endmodule

bind vec_irq_unit vec_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .instrEnd   (instrEnd),
  .statusByte (statusByte),
  .takeIrq    (takeIrq),
  .vecAddr    (vecAddr)
);

// File: tb/vec_irq_unit_bench.sv
module vec_irq_unit_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrEnd = 0, trapPin = 0, r75Pin = 0, r65Pin = 0, r55Pin = 0;
  logic eiCmd = 0, diCmd = 0, maskWr = 0, serialIn = 0;
  logic [4:0]  maskData = '0;
  logic [7:0]  statusByte;
  logic        takeIrq;
  logic [15:0] vecAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          take;
    logic [15:0] vec;
    string       tag;
  } expT;
  expT expQ[$];
  bit  boundSeen = 0;

  always #4 clk = ~clk;

  vec_irq_unit u_vec_irq_unit (
    .clk(clk), .rstN(rstN), .instrEnd(instrEnd), .trapPin(trapPin),
    .r75Pin(r75Pin), .r65Pin(r65Pin), .r55Pin(r55Pin), .eiCmd(eiCmd),
    .diCmd(diCmd), .maskWr(maskWr), .maskData(maskData), .serialIn(serialIn),
    .statusByte(statusByte), .takeIrq(takeIrq), .vecAddr(vecAddr)
  );

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Monitor: judge the cycle after each sampled boundary
  always @(posedge clk) boundSeen <= instrEnd;

  always @(negedge clk) begin
    if (rstN && boundSeen && expQ.size() > 0) begin
      expT e;
      e = expQ.pop_front();
      checks++;
      if (takeIrq !== e.take || (e.take && vecAddr !== e.vec)) begin
        errors++;
        $display("FAIL %s: take=%0b vec=%h expected take=%0b vec=%h",
                 e.tag, takeIrq, vecAddr, e.take, e.vec);
      end
    end else if (rstN && takeIrq) begin
      checks++;
      errors++;
      $display("FAIL R8: take=1 vec=%h expected take=0 away from a boundary", vecAddr);
    end
  end

  // Driver tasks (inputs change at falling edges)
  task automatic boundary(bit expTake, logic [15:0] expVec, string tag, bit withEi = 0);
    expT e;
    e.take = expTake; e.vec = expVec; e.tag = tag;
    expQ.push_back(e);
    instrEnd = 1; eiCmd = withEi;
    tick();
    instrEnd = 0; eiCmd = 0;
    tick();
  endtask

  task automatic enableIrq();
    eiCmd = 1; tick(); eiCmd = 0;
  endtask

  task automatic maskWrite(logic [4:0] d);
    maskWr = 1; maskData = d; tick(); maskWr = 0; maskData = '0;
  endtask

  task automatic pulseR75();
    r75Pin = 1; tick(); r75Pin = 0; tick();
  endtask

  task automatic checkStatus(logic [7:0] exp, string tag);
    checks++;
    if (statusByte !== exp) begin
      errors++;
      $display("FAIL %s: status=%h expected %h", tag, statusByte, exp);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run=hung expected=finished");
    finishRun();
  end

  initial begin
    tick(3);
    rstN = 1;
    tick();
    // R11 reset state
    checkStatus(8'h07, "R11 status after reset");
    checks++;
    if (takeIrq !== 1'b0 || vecAddr !== 16'h0) begin
      errors++;
      $display("FAIL R11: take=%0b vec=%h expected take=0 vec=0000", takeIrq, vecAddr);
    end

    // R6: level request blocked while masked and disabled
    r55Pin = 1; tick();
    checkStatus(8'h17, "R9 r55 pending in bit 4");
    boundary(0, 16'h0, "R6 r55 gated by mask and enable");

    // R10/R7/R2: unmask, enable, take r55
    maskWrite(5'h08);
    checkStatus(8'h10, "R10 masks loaded");
    enableIrq();
    checkStatus(8'h18, "R7 enable set");
    boundary(1, 16'h002C, "R2 r55 vector");
    checkStatus(8'h10, "R7 enable cleared by take");

    // R8: no take without boundary, R1: r65 over r55
    enableIrq();
    tick(3);
    checkStatus(8'h18, "R8 enable held while waiting for boundary");
    r65Pin = 1;
    boundary(1, 16'h0034, "R1 r65 before r55");
    checkStatus(8'h30, "R9 r65 and r55 pending");
    r65Pin = 0; r55Pin = 0;

    // R10: no load without qualifier bit
    maskWrite(5'h05);
    checkStatus(8'h00, "R10 masks unchanged without bit 3");
    maskWrite(5'h0C);
    checkStatus(8'h04, "R10 r75 mask set");

    // R5: captured while masked, taken after unmask
    pulseR75();
    checkStatus(8'h44, "R5 capture while masked");
    enableIrq();
    boundary(0, 16'h0, "R5 masked capture not taken");
    maskWrite(5'h08);
    checkStatus(8'h48, "R5 capture kept after unmask");
    boundary(1, 16'h003C, "R2 r75 vector");
    checkStatus(8'h00, "R5 capture cleared by take");

    // R5: clear by mask-write bit 4
    pulseR75();
    checkStatus(8'h40, "R5 capture before clear");
    maskWrite(5'h10);
    checkStatus(8'h00, "R5 capture cleared by write bit 4");

    // R4: pulse lost if it falls before the boundary
    trapPin = 1; tick(); trapPin = 0; tick();
    boundary(0, 16'h0, "R4 short trap pulse dropped");
    // R3/R4: rising in boundary cycle, enable off
    trapPin = 1;
    boundary(1, 16'h0024, "R3 trap taken with enable off");
    enableIrq();
    boundary(0, 16'h0, "R4 held trap not retaken");
    checkStatus(8'h08, "R7 enable kept without take");
    diCmd = 1; tick(); diCmd = 0;
    checkStatus(8'h00, "R7 disable command");
    trapPin = 0; tick();

    // R1: trap beats waiting r75 capture
    enableIrq();
    pulseR75();
    trapPin = 1;
    boundary(1, 16'h0024, "R1 trap before r75");
    checkStatus(8'h40, "R1 r75 still captured");
    trapPin = 0;
    enableIrq();
    boundary(1, 16'h003C, "R1 r75 taken afterwards");

    // R3: all masks set
    maskWrite(5'h0F);
    trapPin = 1;
    boundary(1, 16'h0024, "R3 trap taken with masks set");
    trapPin = 0; tick();
    checkStatus(8'h07, "R3 masks intact");

    // R7: take and enable in the same cycle
    maskWrite(5'h08);
    r55Pin = 1;
    enableIrq();
    boundary(1, 16'h002C, "R7 take with coincident enable", 1);
    checkStatus(8'h10, "R7 take wins over enable");
    eiCmd = 1; diCmd = 1; tick(); eiCmd = 0; diCmd = 0;
    checkStatus(8'h10, "R7 disable wins over enable");
    r55Pin = 0;

    // R9: serial bit
    serialIn = 1; tick();
    checkStatus(8'h80, "R9 serial bit 7");
    serialIn = 0;

    tick(4);
    if (expQ.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R8: pending=%0d expected 0", expQ.size());
    end
    finishRun();
  end

endmodule